// File: doc/BRIEF.md
# Latched-Address Nonvolatile Byte Memory

This block is a clock-sampled, synthesizable model of a bytewide nonvolatile memory of 8,192 locations. It sits behind a pin-level parallel port: active-low chip select, write strobe and output gate, a 13-bit address and a data bus split into input, output and drive-enable. Every pin is brought into the clock domain through a synchronizer. Each memory cycle starts with a falling chip select, which freezes the address for the whole cycle. A precharge phase follows while chip select is high.

A cycle that starts with the write strobe already low is a write from the start and never drives the bus. A cycle that starts as a read drives the bus only once the access time has passed, and only while the output gate is low. It stops driving as soon as the write strobe goes low. A write lands when the write strobe or chip select rises, whichever comes first. Timing abuse is recorded in sticky flags that only reset clears. All time limits are parameters counted in clock cycles.

Top module: `nvbyte_mem`

## Requirements
- R1: The array holds 2^13 bytes. The three most significant address bits pick one of eight banks, and each location keeps its own value: the same low address in different banks holds different data.
- R2: The address is captured in the cycle where a falling chip select is accepted. Address changes later in that cycle have no effect, and read data comes from the captured address.
- R3: Each pin passes through a two-stage synchronizer. In a read with the output gate low, `dq_oe` first rises after the (T_ACC+2)-th rising clock edge that follows the falling `ce_n`, and not one edge sooner.
- R4: `dq_oe` is high only in a read cycle that has seen at least T_ACC low chip-select samples, with output gate, chip select and write strobe sampled low, low and high. While `oe_n` is high the bus is never driven. When `dq_oe` is low, `dq_out` is zero.
- R5: If `we_n` is low in the sample where chip select falls, the bus stays undriven for the whole cycle, whatever `oe_n` does.
- R6: In a cycle that started as a read, the bus follows `oe_n` until `we_n` is sampled low. From that sample to the end of the cycle the bus is not driven.
- R7: A write is stored at the captured address on the first sample where `we_n` or `ce_n` is high after a low `we_n`. The stored byte is the one from the last sample before that rise, and one write pulse stores exactly once.
- R8: A falling chip select is accepted only after at least T_PC consecutive high samples. An earlier fall is ignored: no cycle starts and nothing is driven. The fall sets `viol[0]`.
- R9: Chip select sampled low for more than T_CE_MAX consecutive samples in a cycle sets `viol[1]`.
- R10: Chip select rising before T_ACC low samples sets `viol[2]`.
- R11: After reset, `dq_oe`, `dq_out` and `viol` are zero and the next falling chip select is accepted at once. The `viol` bits stay set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip select, active low; its fall starts a cycle |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| addr | input | 13 | Byte address |
| dq_in | input | 8 | Data from the bus |
| dq_out | output | 8 | Data to the bus |
| dq_oe | output | 1 | Bus drive enable |
| viol | output | 3 | Sticky flags: [0] short precharge, [1] chip select low too long, [2] early chip-select rise |

## Verification
The bench builds the block with an access of 4 cycles, a precharge of 3 cycles and a chip-select limit of 20 cycles, and keeps the full 13-bit address and 8-bit data. With these short limits a single test can reach every flag: the early rise, the ignored fall during precharge and the over-long cycle. It can also run many complete read and write cycles across all eight banks. The short access count also makes the exact first drive cycle, and the cutover when the write strobe falls in mid-read, easy to observe within a few clocks.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;

    typedef enum logic {
        PH_PRECHARGE = 1'b0,
        PH_ACCESS    = 1'b1
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } ctl_t;

    typedef struct packed {
        logic early_rise;
        logic long_low;
        logic short_pc;
    } viol_t;

    localparam int unsigned VIOL_W = $bits(viol_t);
    localparam int unsigned CTL_W  = $bits(ctl_t);

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nvbyte_sync.sv
module nvbyte_sync #(
    parameter int unsigned W       = 8,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= RST_VAL;
        else     stg[0] <= d;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[i] <= RST_VAL;
            else     stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/nvbyte_bank.sv
module nvbyte_bank #(
    parameter int unsigned AW = 10,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
    import nvbyte_pkg::*;
#(
    parameter int unsigned ADDR_W   = 13,
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned T_ACC    = 15,
    parameter int unsigned T_PC     = 8,
    parameter int unsigned T_CE_MAX = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              s_ctl,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_din,
    output logic [ADDR_W-1:0] lat_addr,
    output logic              wr_stb,
    output logic [DATA_W-1:0] wdata,
    output logic              drive,
    output logic              in_acc,
    output viol_t             viol
);
    localparam int unsigned CNT_W = $clog2(max3(T_ACC, T_PC, T_CE_MAX) + 2);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ACC_LIM = CNT_W'(T_ACC);
    localparam logic [CNT_W-1:0] PC_LIM  = CNT_W'(T_PC);
    localparam logic [CNT_W-1:0] LOW_LIM = CNT_W'(T_CE_MAX);

    phase_e            phase;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  cnt_inc;
    logic              prev_ce_n;
    logic              prev_we_n;
    logic [DATA_W-1:0] prev_din;
    logic              wr_cyc;
    logic              fall_seen;

    assign cnt_inc   = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
    assign fall_seen = prev_ce_n && !s_ctl.ce_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_PRECHARGE;
            cnt       <= PC_LIM;
            prev_ce_n <= 1'b1;
            prev_we_n <= 1'b1;
            prev_din  <= '1;
            wr_cyc    <= 1'b0;
            lat_addr  <= '0;
            viol      <= '0;
        end else begin
            prev_ce_n <= s_ctl.ce_n;
            prev_we_n <= s_ctl.we_n;
            prev_din  <= s_din;
            unique case (phase)
                PH_PRECHARGE: begin
                    if (!s_ctl.ce_n) begin
                        if (fall_seen && cnt >= PC_LIM) begin
                            phase    <= PH_ACCESS;
                            cnt      <= CNT_W'(1);
                            lat_addr <= s_addr;
                            wr_cyc   <= !s_ctl.we_n;
                        end else begin
                            if (fall_seen) viol.short_pc <= 1'b1;
                            cnt <= '0;
                        end
                    end else begin
                        cnt <= cnt_inc;
                    end
                end
                PH_ACCESS: begin
                    if (s_ctl.ce_n) begin
                        phase  <= PH_PRECHARGE;
                        cnt    <= CNT_W'(1);
                        wr_cyc <= 1'b0;
                        if (cnt < ACC_LIM) viol.early_rise <= 1'b1;
                    end else begin
                        cnt <= cnt_inc;
                        if (cnt >= LOW_LIM) viol.long_low <= 1'b1;
                        if (!s_ctl.we_n)    wr_cyc <= 1'b1;
                    end
                end
                default: phase <= PH_PRECHARGE;
            endcase
        end
    end

    assign in_acc = (phase == PH_ACCESS);
    assign wr_stb = in_acc && !prev_we_n && (s_ctl.we_n || s_ctl.ce_n);
    assign wdata  = prev_din;
    assign drive  = in_acc && (cnt >= ACC_LIM) && !wr_cyc
                    && s_ctl.we_n && !s_ctl.oe_n && !s_ctl.ce_n;
endmodule

// File: rtl/nvbyte_mem.sv
module nvbyte_mem
    import nvbyte_pkg::*;
#(
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned BLK_BITS    = 3,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned T_ACC       = 15,
    parameter int unsigned T_PC        = 8,
    parameter int unsigned T_CE_MAX    = 250
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic [VIOL_W-1:0] viol
);
    localparam int unsigned BANK_AW = ADDR_W - BLK_BITS;
    localparam int unsigned NBANK   = 1 << BLK_BITS;
    localparam int unsigned PIPE_W  = CTL_W + ADDR_W + DATA_W;

    logic [PIPE_W-1:0] pin_vec;
    logic [PIPE_W-1:0] smp_vec;
    ctl_t              s_ctl;
    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_din;

    assign pin_vec = {ce_n, we_n, oe_n, addr, dq_in};

    nvbyte_sync #(
        .W      (PIPE_W),
        .STAGES (SYNC_STAGES),
        .RST_VAL({PIPE_W{1'b1}})
    ) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pin_vec),
        .q   (smp_vec)
    );

    assign {s_ctl, s_addr, s_din} = smp_vec;

    logic [ADDR_W-1:0] lat_addr;
    logic              wr_stb;
    logic [DATA_W-1:0] wdata;
    logic              drive;
    logic              in_acc;
    viol_t             viol_s;

    nvbyte_ctrl #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .T_ACC    (T_ACC),
        .T_PC     (T_PC),
        .T_CE_MAX (T_CE_MAX)
    ) ctrl_i (
        .clk      (clk),
        .rst      (rst),
        .s_ctl    (s_ctl),
        .s_addr   (s_addr),
        .s_din    (s_din),
        .lat_addr (lat_addr),
        .wr_stb   (wr_stb),
        .wdata    (wdata),
        .drive    (drive),
        .in_acc   (in_acc),
        .viol     (viol_s)
    );

    logic [BLK_BITS-1:0] blk_sel;
    logic [BANK_AW-1:0]  row_sel;
    logic [DATA_W-1:0]   bank_rd [NBANK];

    assign blk_sel = lat_addr[ADDR_W-1 -: BLK_BITS];
    assign row_sel = lat_addr[BANK_AW-1:0];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        nvbyte_bank #(
            .AW (BANK_AW),
            .DW (DATA_W)
        ) bank_i (
            .clk   (clk),
            .we    (wr_stb && (blk_sel == BLK_BITS'(b))),
            .waddr (row_sel),
            .wdata (wdata),
            .raddr (row_sel),
            .rdata (bank_rd[b])
        );
    end

    assign dq_oe  = drive;
    assign dq_out = drive ? bank_rd[blk_sel] : '0;
    assign viol   = viol_s;
endmodule

// File: rtl/nvbyte_mem_chk.sv
module nvbyte_mem_chk #(
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              dq_oe,
    input logic [2:0]        viol,
    input logic              wr_stb,
    input logic              in_acc,
    input logic [ADDR_W-1:0] lat_addr
);
    // R4: drive only if the output gate was low two samples earlier
    a_r4_gate_low: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !$past(oe_n, 2));

    // R6: no drive while the write strobe is seen low
    a_r6_strobe_high: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> $past(we_n, 2));

    // R8: no drive while chip select is high
    a_r8_select_low: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> !$past(ce_n, 2));

    // R2: captured address holds through the access phase
    a_r2_addr_frozen: assert property (@(posedge clk) disable iff (rst)
        (in_acc && $past(in_acc)) |-> $stable(lat_addr));

    // R7: one store per write pulse
    a_r7_single_store: assert property (@(posedge clk) disable iff (rst)
        wr_stb |=> !wr_stb);

    // R11: flags never clear without reset
    a_r11_flags_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((viol & $past(viol)) == $past(viol)));
endmodule

bind nvbyte_mem nvbyte_mem_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ce_n     (ce_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dq_oe    (dq_oe),
    .viol     (viol),
    .wr_stb   (wr_stb),
    .in_acc   (in_acc),
    .lat_addr (lat_addr)
);

// File: tb/nvbyte_mem_tb_top.sv
module nvbyte_mem_tb_top;
    localparam int TA  = 4;
    localparam int TP  = 3;
    localparam int TCM = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [12:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dq_out;
    logic        dq_oe;
    logic [2:0]  viol;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    nvbyte_mem #(
        .T_ACC(TA), .T_PC(TP), .T_CE_MAX(TCM)
    ) dut_i (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe), .viol(viol)
    );

    // behavioural reference: sampled pins, phase, counters, byte store
    logic        q1c, q1w, q1o, q2c, q2w, q2o;
    logic [12:0] q1a, q2a;
    logic [7:0]  q1d, q2d;
    int          mst, mcnt;
    logic        mpc, mpw, mwr;
    logic [7:0]  mpd;
    logic [12:0] mlat;
    logic [2:0]  mv;
    logic [7:0]  mmem [int];

    always @(posedge clk) begin
        if (rst) begin
            mst = 0; mcnt = TP; mpc = 1; mpw = 1; mpd = 8'hFF;
            mlat = '0; mwr = 0; mv = '0;
            {q1c, q1w, q1o, q1a, q1d} = '1;
            {q2c, q2w, q2o, q2a, q2d} = '1;
        end else begin
            if (mst == 1 && !mpw && (q2w || q2c)) mmem[int'(mlat)] = mpd;
            if (mst == 0) begin
                if (!q2c) begin
                    if (mpc && mcnt >= TP) begin
                        mst = 1; mcnt = 1; mlat = q2a; mwr = !q2w;
                    end else begin
                        if (mpc) mv[0] = 1'b1;
                        mcnt = 0;
                    end
                end else mcnt++;
            end else begin
                if (q2c) begin
                    if (mcnt < TA) mv[2] = 1'b1;
                    mst = 0; mcnt = 1; mwr = 0;
                end else begin
                    if (mcnt >= TCM) mv[1] = 1'b1;
                    mcnt++;
                    if (!q2w) mwr = 1;
                end
            end
            mpc = q2c; mpw = q2w; mpd = q2d;
            {q2c, q2w, q2o, q2a, q2d} = {q1c, q1w, q1o, q1a, q1d};
            {q1c, q1w, q1o, q1a, q1d} = {ce_n, we_n, oe_n, addr, din};
        end
    end

    always @(negedge clk) begin
        if (!rst && !done) begin
            logic exp_oe;
            exp_oe = (mst == 1) && (mcnt >= TA) && !mwr && q2w && !q2o && !q2c;
            vectors++;
            if (dq_oe !== exp_oe) begin
                fails++;
                $display("FAIL R4 dq_oe got %0b exp %0b at %0t", dq_oe, exp_oe, $time);
            end
            if (exp_oe && mmem.exists(int'(mlat))) begin
                vectors++;
                if (dq_out !== mmem[int'(mlat)]) begin
                    fails++;
                    $display("FAIL R2 dq_out got %02h exp %02h", dq_out, mmem[int'(mlat)]);
                end
            end
            if (!exp_oe) begin
                vectors++;
                if (dq_out !== 8'h00) begin
                    fails++;
                    $display("FAIL R4 dq_out idle got %02h exp 00", dq_out);
                end
            end
            vectors++;
            if (viol !== mv) begin
                fails++;
                $display("FAIL R8/R9/R10 viol got %03b exp %03b", viol, mv);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s got %0h exp %0h", req, act, exp);
        end
    endtask

    task automatic ce_write(input logic [12:0] a, input logic [7:0] d);
        we_n = 0; oe_n = 0; addr = a; din = d; ce_n = 0;
        step(TA + 4);
        chk(dq_oe == 1'b0, "R5 ce-write drive", dq_oe, 0);
        ce_n = 1; din = ~d;
        step(1);
        we_n = 1;
        step(TP + 3);
    endtask

    task automatic rd(input logic [12:0] a, input logic [7:0] exp);
        we_n = 1; oe_n = 0; addr = a; ce_n = 0;
        step(1);
        addr = a ^ 13'h1555;
        step(TA);
        chk(dq_oe == 1'b0, "R3 early drive", dq_oe, 0);
        step(1);
        chk(dq_oe == 1'b1, "R3 first drive", dq_oe, 1);
        step(2);
        chk(dq_out == exp, "R2/R1 read data", dq_out, exp);
        ce_n = 1;
        step(TP + 3);
    endtask

    initial begin
        step(4);
        rst = 0;
        step(1);
        chk(dq_oe == 1'b0 && viol == 3'b000 && dq_out == 8'h00, "R11 reset", {viol, dq_oe}, 0);

        // R1: same row in three banks
        ce_write(13'h0005, 8'hA5);
        ce_write(13'h0C05, 8'h3C);
        ce_write(13'h1C05, 8'hE1);
        rd(13'h0005, 8'hA5);
        rd(13'h0C05, 8'h3C);
        rd(13'h1C05, 8'hE1);

        // R6/R7: write-strobe controlled write
        we_n = 1; oe_n = 0; addr = 13'h0123; ce_n = 0;
        step(TA + 4);
        chk(dq_oe == 1'b1, "R6 drive before strobe", dq_oe, 1);
        we_n = 0; din = 8'h5A;
        step(3);
        chk(dq_oe == 1'b0, "R6 drive after strobe", dq_oe, 0);
        we_n = 1; din = 8'h00;
        step(2);
        ce_n = 1;
        step(TP + 3);
        rd(13'h0123, 8'h5A);

        // R4: output gate high
        we_n = 1; oe_n = 1; addr = 13'h0005; ce_n = 0;
        step(TA + 4);
        chk(dq_oe == 1'b0, "R4 gate high", dq_oe, 0);
        ce_n = 1; oe_n = 0;
        step(TP + 3);
        chk(viol == 3'b000, "R11 no flags yet", viol, 0);

        // R8: short precharge, ignored fall
        ce_n = 0; step(TA + 2);
        ce_n = 1; step(1);
        ce_n = 0; step(TA + 4);
        chk(dq_oe == 1'b0, "R8 ignored fall", dq_oe, 0);
        chk(viol == 3'b001, "R8 flag", viol, 1);
        ce_n = 1; step(TP + 3);
        rd(13'h1C05, 8'hE1);

        // R10: early rise
        ce_n = 0; step(2);
        ce_n = 1; step(TP + 3);
        chk(viol == 3'b101, "R10 flag", viol, 5);

        // R9: long low
        ce_n = 0; step(TCM + 3);
        ce_n = 1; step(TP + 3);
        chk(viol == 3'b111, "R9 flag", viol, 7);
        step(30);
        chk(viol == 3'b111, "R11 sticky", viol, 7);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule